// File: doc/BRIEF.md
# Superscalar Decode Stage Controller

This block sits between fetch and rename in an in-order superscalar pipeline. Each cycle it may accept a group of up to `W` instruction slots from fetch. Each slot carries a tag, a "killed" flag and a "no source operands" flag. The stage removes killed slots and packs the survivors into the low slots of the group it passes to rename. Survivors that have no source operands are flagged as ready to issue. The stage does not interpret instructions. It only moves slot tags and the two per-slot flags.

A five-state controller governs the flow. The states are idle, running, blocked, draining and flushing. Three stall lines (rename, execute, commit) hold the stage. Groups that arrive while it is held go into a skid buffer of whole groups. When the stalls clear, these groups are replayed one per cycle, in arrival order. The stall line to fetch stays high until the buffer is empty. A flush request from commit empties the buffer and parks the stage until both flush-related inputs are low. Six free-running counters report cycle and instruction statistics.

Top module: `dec_stage`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `fe_stall_o` is 0, `rn_cnt_o` is 0 and all six counters are 0.
- R2: Suppose the stage is idle or running, with no flush request and no stall. A group with `fe_cnt_i` > 0 is then processed. One clock later, `rn_cnt_o` equals the number of unkilled slots among slots 0..`fe_cnt_i`-1, and `state_o` is 1 (running). Slots at or above `fe_cnt_i` are ignored.
- R3: A slot whose `fe_kill_i` bit is set is dropped. Later surviving slots occupy consecutive output slots starting at slot 0, keeping their order. The killed-instruction counter grows by the number dropped, and the decoded counter grows by `rn_cnt_o`.
- R4: Bit j of `rn_rdy_o` equals the no-source flag of the instruction placed in output slot j. Bits at or above `rn_cnt_o` are 0.
- R5: Suppose the stage is idle, running or draining, with no flush request, and any stall input is high. The next state is then 2 (blocked). Any valid fetch group of that cycle is kept in the skid buffer, nothing is emitted, and `fe_stall_o` is 1 from the next cycle.
- R6: While blocked, every valid fetch group is appended to the skid buffer. `fe_stall_o` stays 1, and the blocked-cycle counter increments every cycle.
- R7: In the blocked state with all stalls low, the next state is 3 (draining) and `fe_stall_o` stays 1. The exception is an empty buffer with no arriving group: the stage then returns directly to running with `fe_stall_o` 0.
- R8: While draining, the head group of the skid buffer is processed in place of the fetch input and then removed. A newly arriving valid group is appended. The drain-cycle counter increments. The stage returns to running, with `fe_stall_o` 0, after the cycle that removes the last group without appending one.
- R9: A commit flush request empties the skid buffer and moves the stage to state 4 (flushing). In the idle, running and draining states, it takes priority over the stalls. In the blocked state, a reorder-buffer flush input also triggers the flush.
- R10: In the flushing state, nothing is emitted and fetch groups are discarded. The flush-cycle counter increments in each flushing cycle that has the commit flush request high. The stage returns to running once both flush inputs are low.
- R11: In the idle or running state, with no stall or flush and no valid group, the next state is 0. Nothing is emitted and the idle-cycle counter increments.
- R12: The skid buffer holds up to `DEPTH` groups, and they replay in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fe_cnt_i | input | CW | Number of slots in the fetch group; 0 means no group |
| fe_kill_i | input | W | Per-slot killed flag |
| fe_nosrc_i | input | W | Per-slot no-source-operand flag |
| fe_tag_i | input | W*TW | Per-slot instruction tags, slot 0 in the low bits |
| stall_ren_i | input | 1 | Stall from rename |
| stall_exe_i | input | 1 | Stall from execute |
| stall_cmt_i | input | 1 | Stall from commit |
| cmt_flush_i | input | 1 | Flush request from commit |
| rob_flush_i | input | 1 | Reorder buffer flushing |
| fe_stall_o | output | 1 | Stall to fetch |
| state_o | output | 3 | 0 idle, 1 running, 2 blocked, 3 draining, 4 flushing |
| rn_cnt_o | output | CW | Number of valid slots sent to rename |
| rn_tag_o | output | W*TW | Packed output tags |
| rn_rdy_o | output | W | Ready-to-issue flag per output slot |
| pc_idle_o | output | PCW | Idle-cycle counter |
| pc_blk_o | output | PCW | Blocked-cycle counter |
| pc_drain_o | output | PCW | Drain-cycle counter |
| pc_flush_o | output | PCW | Flush-cycle counter |
| pc_dec_o | output | PCW | Decoded-instruction counter |
| pc_kill_o | output | PCW | Killed-instruction counter |

## Verification
The assertions rely on two input assumptions. First, `fe_cnt_i` never exceeds `W`. Second, fetch does not send more groups than the skid buffer can hold while `fe_stall_o` is high. The overflow check depends on the second assumption. The bench keeps every group count within 1..`W`. Groups sent against an asserted fetch stall are limited to what fills the buffer exactly to `DEPTH`. Every other group is offered only while `fe_stall_o` is low.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FLUSH = 3'd4
  } dec_state_e;

  localparam int NUM_PC = 6;
  localparam int PC_IDLE  = 0;
  localparam int PC_BLK   = 1;
  localparam int PC_DRAIN = 2;
  localparam int PC_FLUSH = 3;
  localparam int PC_DEC   = 4;
  localparam int PC_KILL  = 5;
endpackage

// File: rtl/dec_skid.sv
module dec_skid #(
  parameter int GW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [GW-1:0] data_i,
  output logic [GW-1:0] head_o,
  output logic [NW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [GW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [NW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == NW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + NW'(1);
        2'b01:   cnt_q <= cnt_q - NW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dec_pack.sv
module dec_pack #(
  parameter int W  = 4,
  parameter int TW = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [CW-1:0]   cnt_i,
  input  logic [W-1:0]    kill_i,
  input  logic [W-1:0]    nosrc_i,
  input  logic [W*TW-1:0] tag_i,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   nkill_o,
  output logic [W-1:0]    rdy_o,
  output logic [W*TW-1:0] tag_o
);
  always_comb begin
    int j;
    int k;
    j     = 0;
    k     = 0;
    rdy_o = '0;
    tag_o = '0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(cnt_i)) begin
        if (kill_i[i]) begin
          k = k + 1;
        end else begin
          tag_o[j*TW +: TW] = tag_i[i*TW +: TW];
          rdy_o[j]          = nosrc_i[i];
          j = j + 1;
        end
      end
    end
    cnt_o   = CW'(j);
    nkill_o = CW'(k);
  end
endmodule

// File: rtl/dec_perf.sv
module dec_perf #(
  parameter int N   = 6,
  parameter int AMW = 3,
  parameter int PCW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AMW-1:0] amt_i [N],
  output logic [PCW-1:0] cnt_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [PCW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= q + PCW'(amt_i[g]);
    end
    assign cnt_o[g] = q;
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int W     = 4,
  parameter int TW    = 8,
  parameter int DEPTH = 4,
  parameter int PCW   = 16,
  localparam int CW   = $clog2(W + 1),
  localparam int GW   = CW + 2*W + W*TW,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW-1:0]   fe_cnt_i,
  input  logic [W-1:0]    fe_kill_i,
  input  logic [W-1:0]    fe_nosrc_i,
  input  logic [W*TW-1:0] fe_tag_i,
  input  logic            stall_ren_i,
  input  logic            stall_exe_i,
  input  logic            stall_cmt_i,
  input  logic            cmt_flush_i,
  input  logic            rob_flush_i,
  output logic            fe_stall_o,
  output logic [2:0]      state_o,
  output logic [CW-1:0]   rn_cnt_o,
  output logic [W*TW-1:0] rn_tag_o,
  output logic [W-1:0]    rn_rdy_o,
  output logic [PCW-1:0]  pc_idle_o,
  output logic [PCW-1:0]  pc_blk_o,
  output logic [PCW-1:0]  pc_drain_o,
  output logic [PCW-1:0]  pc_flush_o,
  output logic [PCW-1:0]  pc_dec_o,
  output logic [PCW-1:0]  pc_kill_o
);
  dec_state_e state_q, state_d;

  logic          fe_vld, any_stall;
  logic          skid_push, skid_pop, skid_flush, skid_full, skid_empty;
  logic [NW-1:0] skid_cnt;
  logic [GW-1:0] fe_grp, skid_head, src_grp;
  logic          use_skid, proc;
  logic          inc_idle, inc_blk, inc_drain, inc_flush;

  logic [CW-1:0]   pk_cnt, pk_nkill;
  logic [W-1:0]    pk_rdy;
  logic [W*TW-1:0] pk_tag;

  assign fe_vld    = (fe_cnt_i != '0);
  assign any_stall = stall_ren_i | stall_exe_i | stall_cmt_i;
  assign fe_grp    = {fe_cnt_i, fe_kill_i, fe_nosrc_i, fe_tag_i};
  assign src_grp   = use_skid ? skid_head : fe_grp;

  always_comb begin
    state_d    = state_q;
    skid_push  = 1'b0;
    skid_pop   = 1'b0;
    skid_flush = 1'b0;
    use_skid   = 1'b0;
    proc       = 1'b0;
    inc_idle   = 1'b0;
    inc_blk    = 1'b0;
    inc_drain  = 1'b0;
    inc_flush  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RUN, ST_DRAIN: begin
        if (cmt_flush_i) begin
          skid_flush = 1'b1;
          state_d    = ST_FLUSH;
        end else if (any_stall) begin
          skid_push = fe_vld;
          state_d   = ST_BLK;
        end else if (state_q == ST_DRAIN) begin
          proc      = 1'b1;
          use_skid  = 1'b1;
          skid_pop  = 1'b1;
          skid_push = fe_vld;
          inc_drain = 1'b1;
          if (skid_cnt == NW'(1) && !fe_vld) state_d = ST_RUN;
        end else if (fe_vld) begin
          proc    = 1'b1;
          state_d = ST_RUN;
        end else begin
          inc_idle = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_BLK: begin
        inc_blk = 1'b1;
        if (cmt_flush_i || rob_flush_i) begin
          skid_flush = 1'b1;
          state_d    = ST_FLUSH;
        end else begin
          skid_push = fe_vld;
          if (!any_stall) state_d = (skid_empty && !fe_vld) ? ST_RUN : ST_DRAIN;
        end
      end
      ST_FLUSH: begin
        if (!cmt_flush_i && !rob_flush_i) begin
          state_d = ST_RUN;
        end else if (cmt_flush_i) begin
          inc_flush  = 1'b1;
          skid_flush = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  dec_skid #(.GW(GW), .DEPTH(DEPTH)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (skid_push),
    .pop_i   (skid_pop),
    .flush_i (skid_flush),
    .data_i  (fe_grp),
    .head_o  (skid_head),
    .cnt_o   (skid_cnt),
    .full_o  (skid_full),
    .empty_o (skid_empty)
  );

  dec_pack #(.W(W), .TW(TW)) u_pack (
    .cnt_i   (src_grp[GW-1 -: CW]),
    .kill_i  (src_grp[2*W+W*TW-1 -: W]),
    .nosrc_i (src_grp[W+W*TW-1 -: W]),
    .tag_i   (src_grp[W*TW-1:0]),
    .cnt_o   (pk_cnt),
    .nkill_o (pk_nkill),
    .rdy_o   (pk_rdy),
    .tag_o   (pk_tag)
  );

  logic [CW-1:0]  pc_amt [NUM_PC];
  logic [PCW-1:0] pc_val [NUM_PC];

  assign pc_amt[PC_IDLE]  = CW'(inc_idle);
  assign pc_amt[PC_BLK]   = CW'(inc_blk);
  assign pc_amt[PC_DRAIN] = CW'(inc_drain);
  assign pc_amt[PC_FLUSH] = CW'(inc_flush);
  assign pc_amt[PC_DEC]   = proc ? pk_cnt : '0;
  assign pc_amt[PC_KILL]  = proc ? pk_nkill : '0;

  dec_perf #(.N(NUM_PC), .AMW(CW), .PCW(PCW)) u_perf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .amt_i  (pc_amt),
    .cnt_o  (pc_val)
  );

  assign pc_idle_o  = pc_val[PC_IDLE];
  assign pc_blk_o   = pc_val[PC_BLK];
  assign pc_drain_o = pc_val[PC_DRAIN];
  assign pc_flush_o = pc_val[PC_FLUSH];
  assign pc_dec_o   = pc_val[PC_DEC];
  assign pc_kill_o  = pc_val[PC_KILL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fe_stall_o <= 1'b0;
      rn_cnt_o   <= '0;
      rn_tag_o   <= '0;
      rn_rdy_o   <= '0;
    end else begin
      state_q    <= state_d;
      fe_stall_o <= (state_d == ST_BLK) || (state_d == ST_DRAIN);
      rn_cnt_o   <= proc ? pk_cnt : '0;
      rn_tag_o   <= proc ? pk_tag : '0;
      rn_rdy_o   <= proc ? pk_rdy : '0;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
  parameter int W  = 4,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    state_o,
  input logic          fe_stall_o,
  input logic [CW-1:0] rn_cnt_o,
  input logic [CW-1:0] fe_cnt_i,
  input logic          stall_ren_i,
  input logic          stall_exe_i,
  input logic          stall_cmt_i,
  input logic          cmt_flush_i,
  input logic          rob_flush_i,
  input logic          skid_push,
  input logic          skid_pop,
  input logic          skid_full
);
  logic active, stall_any;
  assign active    = (state_o == 3'd0) || (state_o == 3'd1) || (state_o == 3'd3);
  assign stall_any = stall_ren_i || stall_exe_i || stall_cmt_i;

  a_r2_in_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_cnt_i <= CW'(W));

  a_r2_out_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rn_cnt_o <= CW'(W));

  a_r5_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !cmt_flush_i && stall_any) |=> (state_o == 3'd2));

  a_r6_stall_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd3) |-> fe_stall_o);

  a_r9_flush_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd4 && state_o != 3'd2 && cmt_flush_i) |=> (state_o == 3'd4));

  a_r10_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |=> (rn_cnt_o == '0));

  a_r10_flush_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !cmt_flush_i && !rob_flush_i) |=> (state_o == 3'd1));

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skid_push |-> (!skid_full || skid_pop));
endmodule

bind dec_stage dec_stage_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_o     (state_o),
  .fe_stall_o  (fe_stall_o),
  .rn_cnt_o    (rn_cnt_o),
  .fe_cnt_i    (fe_cnt_i),
  .stall_ren_i (stall_ren_i),
  .stall_exe_i (stall_exe_i),
  .stall_cmt_i (stall_cmt_i),
  .cmt_flush_i (cmt_flush_i),
  .rob_flush_i (rob_flush_i),
  .skid_push   (skid_push),
  .skid_pop    (skid_pop),
  .skid_full   (skid_full)
);

// File: tb/sim_dec_stage.sv
module sim_dec_stage;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4, TW = 8, DEPTH = 4, PCW = 16;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0]   fe_cnt = '0;
  logic [W-1:0]    fe_kill = '0, fe_nosrc = '0;
  logic [W*TW-1:0] fe_tag = '0;
  logic s_ren = 0, s_exe = 0, s_cmt = 0, c_fl = 0, r_fl = 0;
  logic            fe_stall;
  logic [2:0]      state;
  logic [CW-1:0]   rn_cnt;
  logic [W*TW-1:0] rn_tag;
  logic [W-1:0]    rn_rdy;
  logic [PCW-1:0]  pc_idle, pc_blk, pc_drain, pc_flush, pc_dec, pc_kill;

  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_stage #(.W(W), .TW(TW), .DEPTH(DEPTH), .PCW(PCW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fe_cnt_i(fe_cnt), .fe_kill_i(fe_kill), .fe_nosrc_i(fe_nosrc), .fe_tag_i(fe_tag),
    .stall_ren_i(s_ren), .stall_exe_i(s_exe), .stall_cmt_i(s_cmt),
    .cmt_flush_i(c_fl), .rob_flush_i(r_fl),
    .fe_stall_o(fe_stall), .state_o(state), .rn_cnt_o(rn_cnt), .rn_tag_o(rn_tag),
    .rn_rdy_o(rn_rdy), .pc_idle_o(pc_idle), .pc_blk_o(pc_blk), .pc_drain_o(pc_drain),
    .pc_flush_o(pc_flush), .pc_dec_o(pc_dec), .pc_kill_o(pc_kill)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tag_at(input int j);
    return int'(rn_tag[j*TW +: TW]);
  endfunction

  // group with tags base, base+1, ...
  task automatic grp(input int cnt, input logic [W-1:0] kill, input logic [W-1:0] ns, input int base);
    fe_cnt   = CW'(cnt);
    fe_kill  = kill;
    fe_nosrc = ns;
    for (int i = 0; i < W; i++) fe_tag[i*TW +: TW] = TW'(base + i);
  endtask

  task automatic nogrp();
    grp(0, '0, '0, 0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "state", int'(state), 0);
    chk("R1", "fe_stall", int'(fe_stall), 0);
    chk("R1", "rn_cnt", int'(rn_cnt), 0);
    chk("R1", "pc_dec", int'(pc_dec), 0);
    chk("R1", "pc_blk", int'(pc_blk), 0);
  endtask

  task automatic t_run();
    int idle0;
    grp(3, 4'b0000, 4'b0010, 8'h10);
    tick();
    chk("R2", "state", int'(state), 1);
    chk("R2", "rn_cnt", int'(rn_cnt), 3);
    chk("R2", "tag0", tag_at(0), 8'h10);
    chk("R2", "tag2", tag_at(2), 8'h12);
    chk("R4", "rdy", int'(rn_rdy), 4'b0010);
    idle0 = int'(pc_idle);
    nogrp();
    tick();
    chk("R11", "state", int'(state), 0);
    chk("R11", "rn_cnt", int'(rn_cnt), 0);
    chk("R11", "idle ctr", int'(pc_idle), idle0 + 1);
  endtask

  task automatic t_pack();
    int d0, k0;
    d0 = int'(pc_dec); k0 = int'(pc_kill);
    grp(4, 4'b0101, 4'b1000, 8'h20);
    tick();
    chk("R3", "rn_cnt", int'(rn_cnt), 2);
    chk("R3", "tag0", tag_at(0), 8'h21);
    chk("R3", "tag1", tag_at(1), 8'h23);
    chk("R3", "tag2 empty", tag_at(2), 0);
    chk("R4", "rdy", int'(rn_rdy), 4'b0010);
    chk("R3", "kill ctr", int'(pc_kill), k0 + 2);
    chk("R3", "dec ctr", int'(pc_dec), d0 + 2);
    grp(2, 4'b1000, 4'b1100, 8'h28);
    tick();
    chk("R2", "slots above count ignored", int'(rn_cnt), 2);
    chk("R4", "rdy above count", int'(rn_rdy), 4'b0000);
    nogrp();
    tick();
  endtask

  task automatic t_block();
    int b0, u0c;
    b0 = int'(pc_blk); u0c = int'(pc_drain);
    s_exe = 1; grp(2, '0, 4'b0001, 8'h30);
    tick();
    chk("R5", "state", int'(state), 2);
    chk("R5", "fe_stall", int'(fe_stall), 1);
    chk("R5", "no output", int'(rn_cnt), 0);
    grp(1, '0, '0, 8'h40);
    tick();
    chk("R6", "state", int'(state), 2);
    chk("R6", "fe_stall", int'(fe_stall), 1);
    chk("R6", "no output", int'(rn_cnt), 0);
    s_exe = 0; nogrp();
    tick();
    chk("R7", "state", int'(state), 3);
    chk("R7", "fe_stall", int'(fe_stall), 1);
    chk("R6", "blk ctr", int'(pc_blk), b0 + 2);
    grp(1, '0, '0, 8'h50);
    tick();
    chk("R8", "first replay cnt", int'(rn_cnt), 2);
    chk("R8", "first replay tag", tag_at(0), 8'h30);
    chk("R4", "replay rdy", int'(rn_rdy), 4'b0001);
    chk("R8", "still draining", int'(state), 3);
    nogrp();
    tick();
    chk("R8", "second replay tag", tag_at(0), 8'h40);
    chk("R8", "still draining 2", int'(state), 3);
    chk("R8", "stall held", int'(fe_stall), 1);
    tick();
    chk("R8", "third replay tag", tag_at(0), 8'h50);
    chk("R8", "back to run", int'(state), 1);
    chk("R8", "stall released", int'(fe_stall), 0);
    chk("R8", "drain ctr", int'(pc_drain), u0c + 3);
    tick();
  endtask

  task automatic t_blk_direct();
    s_ren = 1; nogrp();
    tick();
    chk("R5", "empty block", int'(state), 2);
    s_ren = 0;
    tick();
    chk("R7", "direct to run", int'(state), 1);
    chk("R7", "stall low", int'(fe_stall), 0);
    tick();
  endtask

  task automatic t_flush();
    int f0;
    s_cmt = 1; grp(2, '0, '0, 8'h60);
    tick();
    chk("R5", "blocked", int'(state), 2);
    c_fl = 1; nogrp();
    tick();
    chk("R9", "flush from blocked", int'(state), 4);
    f0 = int'(pc_flush);
    s_cmt = 0; grp(3, '0, '0, 8'h70);
    tick();
    chk("R10", "still flushing", int'(state), 4);
    chk("R10", "no output", int'(rn_cnt), 0);
    chk("R10", "flush ctr", int'(pc_flush), f0 + 1);
    c_fl = 0; r_fl = 1; nogrp();
    tick();
    chk("R10", "rob flush holds", int'(state), 4);
    chk("R10", "flush ctr unchanged", int'(pc_flush), f0 + 1);
    r_fl = 0;
    tick();
    chk("R10", "exit to run", int'(state), 1);
    s_ren = 1;
    tick();
    s_ren = 0;
    tick();
    chk("R9", "buffer emptied", int'(state), 1);
    chk("R9", "no replay", int'(rn_cnt), 0);
    // rob flush alone from blocked
    s_exe = 1; grp(1, '0, '0, 8'h78);
    tick();
    r_fl = 1; nogrp();
    tick();
    chk("R9", "rob flush from blocked", int'(state), 4);
    s_exe = 0; r_fl = 0;
    tick();
    chk("R10", "exit after rob", int'(state), 1);
    tick();
  endtask

  task automatic t_prio();
    c_fl = 1; s_ren = 1; grp(2, '0, '0, 8'h80);
    tick();
    chk("R9", "flush beats stall", int'(state), 4);
    chk("R9", "no output", int'(rn_cnt), 0);
    c_fl = 0; s_ren = 0; nogrp();
    tick();
    tick();
  endtask

  task automatic t_full();
    s_ren = 1;
    for (int g = 0; g < DEPTH; g++) begin
      grp(1, '0, '0, 8'h90 + g*16);
      tick();
    end
    chk("R12", "blocked full", int'(state), 2);
    s_ren = 0; nogrp();
    tick();
    chk("R12", "draining", int'(state), 3);
    for (int g = 0; g < DEPTH; g++) begin
      tick();
      chk("R12", "replay order", tag_at(0), 8'h90 + g*16);
    end
    chk("R12", "back to run", int'(state), 1);
    chk("R12", "stall low", int'(fe_stall), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_run();
    t_pack();
    t_block();
    t_blk_direct();
    t_flush();
    t_prio();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule